// File: doc/BRIEF.md
# Rotating-Ring Event Scheduler for Sparse Sieve Progressions

This station feeds a wide sieve pipeline with contributions from arithmetic progressions whose step is larger than the pipeline width. The pipeline handles S consecutive indices per cycle, called a group. Each stored event pairs a step `p` with the next index `a` that the progression hits. In every cycle the pipeline reports the group it is processing. The station then reads the ring slot that holds the events of the next group and emits, for each stored event, a contribution: the weight floor(log2 p), the full index, and the pipeline line `a mod S`.

After an event is emitted it is moved forward to `a + p`. It is written straight into the ring slot whose group will be read just before that index reaches the pipeline. The events therefore come out in index order without any sorting. The slot that has just been read is freed in the same cycle, so the read head sweeps round the ring and the rescheduled events land a few slots ahead of it.

Each slot holds K sub-entries. A slot that is full passes an event on to the following slot, where it is emitted one group late and flagged. When the following slot is full as well, the event is dropped and an overflow pulse is raised. Events are loaded into the ring before sieving starts, while `step` is low. Correct operation assumes S ≤ p ≤ (N−3)·S+1, with S and N powers of two.

Top module: `ring_sched_station`

## Requirements
- R1: While `rst_n` is low at a clock edge, every ring sub-entry is emptied. After that edge `out_vld`, `out_late` and `ovf` read 0.
- R2: A load (`ld_en` high, `step` low) stores the event (`ld_p`, `ld_a`) in the first free sub-entry of slot `(ld_a >> LGS) mod N`.
- R3: A cycle with `step` high and `grp_in = g` reads slot `(g+1) mod N`. One cycle later, each lane k that held an event shows `out_vld[k]=1`, `out_idx[k]=a`, `out_line[k]=a mod S` (the low LGS bits of a) and `out_logp[k]=floor(log2 p)`.
- R4: A sub-entry that is empty produces no contribution: its lane shows `out_vld[k]=0`.
- R5: Each emitted event is rescheduled to `a+p` into slot `((a+p) >> LGS) mod N`. Over a run, every multiple of each loaded step inside the swept index window is emitted exactly once, in the group the pipeline is processing at that moment.
- R6: When the target slot is full, the event goes into the next slot `(t+1) mod N`. It is emitted one group later with `out_late[k]=1`. Events that are emitted on time show `out_late[k]=0`.
- R7: When both the target slot and the next slot are full, the event is dropped and `ovf` is 1 in the following cycle only.
- R8: A load presented while `step` is high is ignored.
- R9: The slot being read is emptied in that cycle and is never the destination of a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load an initial event (honoured only when `step` is low) |
| ld_p | input | PW | Step of the event being loaded |
| ld_a | input | AW | First index of the event being loaded |
| step | input | 1 | Pipeline advances this cycle |
| grp_in | input | AW−LGS | Group the pipeline is processing now |
| out_vld | output | K | Contribution valid, one bit per lane |
| out_idx | output | K×AW | Index each contribution belongs to |
| out_line | output | K×LGS | Pipeline line (`index mod S`) |
| out_logp | output | K×LW | Contribution weight, floor(log2 p) |
| out_late | output | K | Contribution emitted one group after its index |
| ovf | output | 1 | An event was dropped in the previous cycle |

## Verification
The bench loads three steps and sweeps forty groups. It expects each multiple in the window once, in its own group, with the correct line and weight. A slot computed off by one would surface as wrong-group or missing indices, and a read slot that was not freed would show up as duplicates. Four events aimed at one group force a spill: a design that overwrote an occupied sub-entry would lose an index, and one that did not flag the spill would show `out_late` low. A seventh event aimed at two full slots must raise a single-cycle `ovf` and never be emitted. Loads during a step, and steps over empty slots, must produce no output.

// File: rtl/rs_pkg.sv
// Shared widths and the stored event record for the ring scheduler.
package rs_pkg;
    localparam int AW = 16;   // index width
    localparam int PW = 12;   // step width (must be below AW)

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] p;
        logic [AW-1:0] a;
    } rs_event_t;
endpackage

// File: rtl/rs_ilog2.sv
// Floor of log2 of an unsigned value (returns 0 for input 0).
// Assumes OW is wide enough to hold W-1.
module rs_ilog2 #(
    parameter int W  = 12,
    parameter int OW = 4
) (
    input  logic [W-1:0]  v,
    output logic [OW-1:0] lg
);
    // Priority scan: the highest set bit wins.
    always_comb begin
        lg = '0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) lg = OW'(i);
        end
    end
endmodule

// File: rtl/rs_alloc.sv
// Sub-entry allocator for the ring. Requests are served in lane order.
// Each request takes the lowest free sub-entry of its target slot; failing
// that, the lowest free sub-entry of the next slot (flagged as a spill);
// failing both, it is reported as dropped. The blocked slot, which is the
// one being read, is treated as full. Assumes N is a power of two.
module rs_alloc #(
    parameter int N  = 8,
    parameter int K  = 3,
    parameter int R  = 3,
    parameter int SW = 3,
    parameter int KW = 2
) (
    input  logic [N-1:0][K-1:0]  occ,
    input  logic                 blk_en,
    input  logic [SW-1:0]        blk_slot,
    input  logic [R-1:0]         req,
    input  logic [R-1:0][SW-1:0] req_slot,
    output logic [R-1:0]         gnt,
    output logic [R-1:0][SW-1:0] g_slot,
    output logic [R-1:0][KW-1:0] g_sub,
    output logic [R-1:0]         g_spill,
    output logic [R-1:0]         dropped
);
    logic [N-1:0][K-1:0] occ_v;
    logic                found;
    logic [SW-1:0]       t1;
    logic [SW-1:0]       t2;

    // Sequential-in-lane allocation over a running occupancy map.
    always_comb begin
        occ_v   = occ;
        if (blk_en) occ_v[blk_slot] = '1;
        gnt     = '0;
        g_slot  = '0;
        g_sub   = '0;
        g_spill = '0;
        dropped = '0;
        found   = 1'b0;
        t1      = '0;
        t2      = '0;
        for (int r = 0; r < R; r++) begin
            found = 1'b0;
            t1    = req_slot[r];
            t2    = req_slot[r] + SW'(1);
            if (req[r]) begin
                for (int k = 0; k < K; k++) begin
                    if (!found && !occ_v[t1][k]) begin
                        found     = 1'b1;
                        g_slot[r] = t1;
                        g_sub[r]  = KW'(k);
                    end
                end
                for (int k = 0; k < K; k++) begin
                    if (!found && !occ_v[t2][k]) begin
                        found      = 1'b1;
                        g_slot[r]  = t2;
                        g_sub[r]   = KW'(k);
                        g_spill[r] = 1'b1;
                    end
                end
                if (found) begin
                    gnt[r] = 1'b1;
                    occ_v[g_slot[r]][g_sub[r]] = 1'b1;
                end else begin
                    dropped[r] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ring_sched_station.sv
// Ring-memory event scheduler. It keeps N slots of K events each. With
// step high and grp_in = g it reads slot (g+1) mod N, registers one
// contribution per occupied sub-entry, frees the slot and rewrites each
// event at a+p into the slot of its new group. Loads are accepted only
// while step is low. Assumes S <= p <= (N-3)*S+1 and power-of-two S, N.
module ring_sched_station
    import rs_pkg::*;
#(
    parameter int LGS = 2,   // log2 of indices per group
    parameter int LGN = 3,   // log2 of ring slots
    parameter int K   = 3    // sub-entries per slot
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic [PW-1:0]                ld_p,
    input  logic [AW-1:0]                ld_a,
    input  logic                         step,
    input  logic [AW-LGS-1:0]            grp_in,
    output logic [K-1:0]                 out_vld,
    output logic [K-1:0][AW-1:0]         out_idx,
    output logic [K-1:0][LGS-1:0]        out_line,
    output logic [K-1:0][$clog2(PW)-1:0] out_logp,
    output logic [K-1:0]                 out_late,
    output logic                         ovf
);
    localparam int N  = 1 << LGN;
    localparam int GW = AW - LGS;
    localparam int LW = $clog2(PW);
    localparam int KW = (K > 1) ? $clog2(K) : 1;

    rs_event_t             mem [N][K];
    logic [N-1:0][K-1:0]   occ;
    logic [GW-1:0]         rd_grp;
    logic [LGN-1:0]        rd_slot;
    rs_event_t [K-1:0]     rd_ev;
    logic [K-1:0][AW-1:0]  nxt_a;
    logic [K-1:0][LW-1:0]  lg;
    logic [K-1:0]          req;
    logic [K-1:0][LGN-1:0] req_slot;
    rs_event_t [K-1:0]     req_ev;
    logic [K-1:0]          gnt;
    logic [K-1:0][LGN-1:0] g_slot;
    logic [K-1:0][KW-1:0]  g_sub;
    logic [K-1:0]          g_spill;
    logic [K-1:0]          dropped;

    assign rd_grp  = grp_in + GW'(1);
    assign rd_slot = rd_grp[LGN-1:0];

    // Occupancy map taken from the valid bits of the ring.
    always_comb begin
        for (int n = 0; n < N; n++)
            for (int k = 0; k < K; k++)
                occ[n][k] = mem[n][k].vld;
    end

    // Read the head slot and build the write requests (reschedule or load).
    always_comb begin
        for (int k = 0; k < K; k++) begin
            rd_ev[k] = mem[rd_slot][k];
            nxt_a[k] = rd_ev[k].a + AW'(rd_ev[k].p);
            if (step) begin
                req[k]      = rd_ev[k].vld;
                req_slot[k] = nxt_a[k][LGS +: LGN];
                req_ev[k]   = '{vld: 1'b1, p: rd_ev[k].p, a: nxt_a[k]};
            end else if (k == 0) begin
                req[k]      = ld_en;
                req_slot[k] = ld_a[LGS +: LGN];
                req_ev[k]   = '{vld: 1'b1, p: ld_p, a: ld_a};
            end else begin
                req[k]      = 1'b0;
                req_slot[k] = '0;
                req_ev[k]   = '0;
            end
        end
    end

    // One weight encoder per lane.
    for (genvar k = 0; k < K; k++) begin : g_lg
        rs_ilog2 #(.W(PW), .OW(LW)) u_lg (.v(rd_ev[k].p), .lg(lg[k]));
    end

    rs_alloc #(.N(N), .K(K), .R(K), .SW(LGN), .KW(KW)) u_alloc (
        .occ      (occ),
        .blk_en   (step),
        .blk_slot (rd_slot),
        .req      (req),
        .req_slot (req_slot),
        .gnt      (gnt),
        .g_slot   (g_slot),
        .g_sub    (g_sub),
        .g_spill  (g_spill),
        .dropped  (dropped)
    );

    // Ring update: free the read slot, then place the granted events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N; n++)
                for (int k = 0; k < K; k++)
                    mem[n][k].vld <= 1'b0;
        end else begin
            if (step)
                for (int k = 0; k < K; k++)
                    mem[rd_slot][k].vld <= 1'b0;
            for (int r = 0; r < K; r++)
                if (gnt[r]) mem[g_slot[r]][g_sub[r]] <= req_ev[r];
        end
    end

    // Contribution registers and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_idx  <= '0;
            out_line <= '0;
            out_logp <= '0;
            out_late <= '0;
            ovf      <= 1'b0;
        end else begin
            for (int k = 0; k < K; k++) begin
                out_vld[k]  <= step && rd_ev[k].vld;
                out_idx[k]  <= rd_ev[k].a;
                out_line[k] <= rd_ev[k].a[LGS-1:0];
                out_logp[k] <= lg[k];
                out_late[k] <= step && rd_ev[k].vld && (rd_ev[k].a[AW-1:LGS] != rd_grp);
            end
            ovf <= |dropped;
        end
    end

    // R3
    emit_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_vld) |-> $past(step));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (occ[$past(rd_slot)] == '0));

    for (genvar r = 0; r < K; r++) begin : g_chk
        // R9
        no_write_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && gnt[r]) |-> (g_slot[r] != rd_slot));
        // R2
        write_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[r] |-> !occ[g_slot[r]][g_sub[r]]);
        // R6
        spill_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[r] && g_spill[r]) |-> (g_slot[r] == req_slot[r] + LGN'(1)));
        for (genvar q = r + 1; q < K; q++) begin : g_pair
            // R5
            no_double_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt[r] && gnt[q]) |-> ({g_slot[r], g_sub[r]} != {g_slot[q], g_sub[q]}));
        end
    end
endmodule

// File: tb/tb_ring_sched_station.sv
module tb_ring_sched_station;
    import rs_pkg::*;
    localparam int LGS = 2;
    localparam int LGN = 3;
    localparam int K   = 3;
    localparam int S   = 1 << LGS;
    localparam int GW  = AW - LGS;
    localparam int LW  = $clog2(PW);
    localparam int G   = 40;               // groups swept
    localparam int LO  = S;                // first index in window (group 1)
    localparam int HI  = S * (G + 1) - 1;  // last index in window
    // Stimulus table: step and expected weight.
    localparam int NP = 3;
    localparam int PT [NP] = '{5, 11, 17};
    localparam int LT [NP] = '{2, 3, 4};

    logic clk = 1'b0;
    logic rst_n, ld_en, step;
    logic [PW-1:0] ld_p;
    logic [AW-1:0] ld_a;
    logic [GW-1:0] grp_in;
    logic [K-1:0] out_vld, out_late;
    logic [K-1:0][AW-1:0] out_idx;
    logic [K-1:0][LGS-1:0] out_line;
    logic [K-1:0][LW-1:0] out_logp;
    logic ovf;

    int checks = 0;
    int errors = 0;
    int hit [NP][0:HI];
    bit done = 1'b0;

    always #5 clk = ~clk;

    ring_sched_station #(.LGS(LGS), .LGN(LGN), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_p(ld_p), .ld_a(ld_a),
        .step(step), .grp_in(grp_in), .out_vld(out_vld), .out_idx(out_idx),
        .out_line(out_line), .out_logp(out_logp), .out_late(out_late), .ovf(ovf));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply inputs for one cycle; return 1 ns after the edge.
    task automatic cyc(input bit le, input int p, input int a, input bit st, input int g);
        ld_en  = le;
        ld_p   = PW'(p);
        ld_a   = AW'(a);
        step   = st;
        grp_in = GW'(g);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    function automatic bit lane_has(input int idx, input bit late);
        for (int k = 0; k < K; k++)
            if (out_vld[k] && int'(out_idx[k]) == idx && out_late[k] == late) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++)
            for (int j = 0; j <= HI; j++) hit[i][j] = 0;
        ld_en = 0; ld_p = '0; ld_a = '0; step = 0; grp_in = '0; rst_n = 0;
        #2;
        do_reset();
        // R1: reset state
        chk(out_vld == '0, "R1", "out_vld after reset", int'(out_vld), 0);
        chk(out_late == '0 && !ovf, "R1", "late/ovf after reset", int'({out_late, ovf}), 0);

        // R2/R3/R5: load table, then sweep the window
        for (int i = 0; i < NP; i++)
            cyc(1, PT[i], ((LO + PT[i] - 1) / PT[i]) * PT[i], 0, 0);
        for (int g = 0; g < G; g++) begin
            cyc(0, 0, 0, 1, g);
            for (int k = 0; k < K; k++) begin
                if (out_vld[k]) begin
                    automatic int idx = int'(out_idx[k]);
                    automatic int pi  = -1;
                    for (int i = 0; i < NP; i++) if (int'(out_logp[k]) == LT[i]) pi = i;
                    chk(int'(out_line[k]) == idx % S, "R3", "line", int'(out_line[k]), idx % S);
                    chk(idx / S == g + 1, "R5", "group of emission", idx / S, g + 1);
                    chk(!out_late[k], "R6", "late on on-time event", int'(out_late[k]), 0);
                    chk(pi >= 0, "R3", "weight", int'(out_logp[k]), LT[0]);
                    if (pi >= 0) begin
                        chk(idx % PT[pi] == 0, "R5", "index multiple of step", idx % PT[pi], 0);
                        if (idx <= HI) hit[pi][idx]++;
                    end
                end
            end
        end
        for (int i = 0; i < NP; i++)
            for (int j = LO; j <= HI; j++)
                if (j % PT[i] == 0)
                    chk(hit[i][j] == 1, "R5", $sformatf("count of %0d for step %0d", j, PT[i]),
                        hit[i][j], 1);

        // R4/R8: empty slot emits nothing; load during step is ignored
        do_reset();
        cyc(0, 0, 0, 1, 3);
        chk(out_vld == '0, "R4", "empty slot output", int'(out_vld), 0);
        cyc(1, 7, 16, 1, 0);
        cyc(0, 0, 0, 1, 3);
        chk(out_vld == '0, "R8", "load during step stored", int'(out_vld), 0);

        // R2/R3: single load emitted in its group
        do_reset();
        cyc(1, 5, 30, 0, 0);
        cyc(0, 0, 0, 1, 6);
        chk($countones(out_vld) == 1, "R2", "emission count", $countones(out_vld), 1);
        chk(out_vld[0] && out_idx[0] == 30, "R2", "emitted index", int'(out_idx[0]), 30);
        chk(out_line[0] == 2 && out_logp[0] == 2, "R3", "line/weight",
            int'({out_line[0], out_logp[0]}), (2 << LW) | 2);

        // R6: fourth event into one group spills and is flagged late
        do_reset();
        cyc(1, 5, 8, 0, 0);
        cyc(1, 11, 9, 0, 0);
        cyc(1, 17, 10, 0, 0);
        cyc(1, 7, 11, 0, 0);
        cyc(0, 0, 0, 1, 1);
        chk($countones(out_vld) == 3, "R6", "on-time emissions", $countones(out_vld), 3);
        chk(lane_has(8, 0) && lane_has(9, 0) && lane_has(10, 0), "R6", "indices 8..10 on time",
            int'(out_vld), 7);
        cyc(0, 0, 0, 1, 2);
        chk(lane_has(11, 1), "R6", "spilled index 11 late", int'(out_late), 1);
        chk(lane_has(13, 0), "R5", "rescheduled index 13 on time", int'(out_vld), 3);

        // R7: both slots full -> drop and one-cycle ovf
        do_reset();
        cyc(1, 5, 8, 0, 0);
        cyc(1, 5, 9, 0, 0);
        cyc(1, 5, 10, 0, 0);
        cyc(1, 5, 12, 0, 0);
        cyc(1, 5, 13, 0, 0);
        cyc(1, 5, 14, 0, 0);
        chk(!ovf, "R7", "ovf before drop", int'(ovf), 0);
        cyc(1, 5, 11, 0, 0);
        chk(ovf, "R7", "ovf on drop", int'(ovf), 1);
        cyc(0, 0, 0, 0, 0);
        chk(!ovf, "R7", "ovf pulse width", int'(ovf), 0);
        cyc(0, 0, 0, 1, 1);
        chk(!lane_has(11, 0) && !lane_has(11, 1), "R7", "dropped index emitted", 11, 0);
        chk($countones(out_vld) == 3, "R7", "surviving emissions", $countones(out_vld), 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule